// File: doc/BRIEF.md
# Paged LCD Write Controller

This block sits behind a register bus and fills the frame store of a 128 by 64 monochrome panel. The frame store is organised as eight horizontal pages, each made of 128 column bytes; each byte covers eight vertically stacked pixels. Software writes to three registers: a mode register, an instruction register and a data register. The mode register decides how a byte written to the data register is treated. In pixel mode the byte is stored in the frame store. In command mode the byte is decoded as a command.

The only command is page select, with byte codes 0xB0 through 0xB7. It moves the write pointer to the start of a page. The column pointer advances after every stored byte and wraps within the current page. A separate lookup port lets a display scanner fetch any single pixel by its (x, y) coordinate.

The mode is held by a three-state machine with the states MODE_OFF, MODE_CMD and MODE_DATA. Every write to the mode register is a transition. Its target depends only on the value written:

- The key 0x00100011 moves the machine to MODE_DATA.
- The key 0x00104011 moves it to MODE_CMD.
- Any other value moves it to MODE_OFF.

Without a mode-register write, the machine stays in its current state. Reset forces MODE_OFF.

Top module: `lcd_page_writer`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) puts the mode in MODE_OFF, sets page and column to 0 and clears every frame-store byte to 0.
- R2: A write to the mode register at offset 0x1AC behaves as follows. The value 0x00100011 selects MODE_DATA. The value 0x00104011 selects MODE_CMD. Any other 32-bit value selects MODE_OFF.
- R3: A write to the instruction register at offset 0x1BC whose full 32-bit value lies in 0xB0..0xB7 sets the page to (value − 0xB0) and the column to 0. This holds in every mode.
- R4: In MODE_CMD, a write to the data register at offset 0x1C0 with a value in 0xB0..0xB7 has exactly the effect given in R3.
- R5: In MODE_DATA, a write to the data register stores bits 7:0 at frame-store byte page×128 + column. The column then increases by one.
- R6: The column advances modulo 128. After column 127 the next byte goes to column 0 of the same page.
- R7: Some writes leave the frame store, the page and the column unchanged. These are: a data-register write in MODE_OFF; an instruction write outside 0xB0..0xB7 (for example 0xAF, 0xB8 or 0x1B0); and a MODE_CMD data write outside that range.
- R8: The pixel port returns bit (y mod 8) of frame-store byte x + (y/8)×128. The result appears on pix_bit one clock edge after pix_x and pix_y are presented.
- R9: Writes to any offset other than 0x1AC, 0x1BC and 0x1C0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write value |
| pix_x | input | 7 | Pixel column, 0..127 |
| pix_y | input | 6 | Pixel row, 0..63 |
| pix_bit | output | 1 | Pixel value, registered |

## Verification
The checker assumes the following about the inputs:

- At most one register write arrives per clock.
- wr_addr and wr_data are only meaningful while wr_en is high.
- The pixel coordinates are always in range, which their widths enforce.

The stimulus respects these assumptions. Each write is a single-cycle strobe, with all inputs changed on the falling edge. wr_en returns low between writes. Pixel checks are made only after each write has settled, so the frame store is never read and written at the same place within one cycle.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_CMD  = 2'd1,
        MODE_DATA = 2'd2
    } lcd_mode_e;
endpackage

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] DATA_KEY = 32'h0010_0011,
    parameter logic [31:0] CMD_KEY  = 32'h0010_4011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wr_data,
    output lcd_mode_e         mode_q,
    output logic              is_cmd,
    output logic              is_data
);
    lcd_mode_e mode_d;
    logic      key_data;
    logic      key_cmd;

    assign key_data = (wr_data == DATA_W'(DATA_KEY));
    assign key_cmd  = (wr_data == DATA_W'(CMD_KEY));

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        if (mode_wr) begin
            unique case ({key_cmd, key_data})
                2'b01:   mode_d = MODE_DATA;
                2'b10:   mode_d = MODE_CMD;
                default: mode_d = MODE_OFF;
            endcase
        end
    end

    always_comb begin
        is_cmd  = 1'b0;
        is_data = 1'b0;
        unique case (mode_q)
            MODE_CMD:  is_cmd  = 1'b1;
            MODE_DATA: is_data = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lcd_ptr.sv
module lcd_ptr #(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid,
    input  logic [PAGE_W-1:0] sel_page,
    input  logic              push,
    output logic [PAGE_W-1:0] page_q,
    output logic [COL_W-1:0]  col_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else if (sel_valid) begin
            page_q <= sel_page;
            col_q  <= '0;
        end else if (push) begin
            col_q  <= col_q + COL_W'(1);
        end
    end
endmodule

// File: rtl/lcd_vram.sv
module lcd_vram #(
    parameter int DEPTH = 1024,
    parameter int VA_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [VA_W-1:0] waddr,
    input  logic [7:0]      wbyte,
    input  logic [VA_W-1:0] raddr,
    input  logic [2:0]      rbit,
    output logic            rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            rdata <= 1'b0;
        end else begin
            if (we) mem[waddr] <= wbyte;
            rdata <= mem[raddr][rbit];
        end
    end
endmodule

// File: rtl/lcd_page_writer.sv
module lcd_page_writer
    import lcd_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter int          COLS      = 128,
    parameter int          PAGES     = 8,
    parameter logic [11:0] MODE_OFS  = 12'h1AC,
    parameter logic [11:0] INST_OFS  = 12'h1BC,
    parameter logic [11:0] DATA_OFS  = 12'h1C0,
    parameter logic [31:0] DATA_KEY  = 32'h0010_0011,
    parameter logic [31:0] CMD_KEY   = 32'h0010_4011,
    parameter logic [31:0] PAGE_BASE = 32'h0000_00B0,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int Y_W    = $clog2(PAGES * 8),
    localparam int DEPTH  = COLS * PAGES,
    localparam int VA_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [COL_W-1:0]  pix_x,
    input  logic [Y_W-1:0]    pix_y,
    output logic              pix_bit
);
    lcd_mode_e         mode_q;
    logic              is_cmd, is_data;
    logic              hit_mode, hit_inst, hit_data;
    logic              page_code, sel_valid, push;
    logic [PAGE_W-1:0] sel_page;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;

    assign hit_mode  = wr_en && (wr_addr == ADDR_W'(MODE_OFS));
    assign hit_inst  = wr_en && (wr_addr == ADDR_W'(INST_OFS));
    assign hit_data  = wr_en && (wr_addr == ADDR_W'(DATA_OFS));

    assign page_code = (wr_data >= DATA_W'(PAGE_BASE)) &&
                       (wr_data <= DATA_W'(PAGE_BASE + PAGES - 1));
    assign sel_page  = wr_data[PAGE_W-1:0] - PAGE_BASE[PAGE_W-1:0];
    assign sel_valid = page_code && (hit_inst || (hit_data && is_cmd));
    assign push      = hit_data && is_data;

    lcd_mode_fsm #(
        .DATA_W(DATA_W), .DATA_KEY(DATA_KEY), .CMD_KEY(CMD_KEY)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .mode_wr(hit_mode), .wr_data(wr_data),
        .mode_q(mode_q), .is_cmd(is_cmd), .is_data(is_data)
    );

    lcd_ptr #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_page(sel_page),
        .push(push), .page_q(page_q), .col_q(col_q)
    );

    lcd_vram #(.DEPTH(DEPTH), .VA_W(VA_W)) u_vram (
        .clk(clk), .rst_n(rst_n), .we(push),
        .waddr({page_q, col_q}), .wbyte(wr_data[7:0]),
        .raddr({pix_y[Y_W-1:3], pix_x}), .rbit(pix_y[2:0]),
        .rdata(pix_bit)
    );
endmodule

// File: rtl/lcd_page_writer_chk.sv
module lcd_page_writer_chk
    import lcd_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter int          COL_W     = 7,
    parameter int          PAGE_W    = 3,
    parameter logic [11:0] MODE_OFS  = 12'h1AC,
    parameter logic [11:0] INST_OFS  = 12'h1BC,
    parameter logic [11:0] DATA_OFS  = 12'h1C0,
    parameter logic [31:0] DATA_KEY  = 32'h0010_0011,
    parameter logic [31:0] CMD_KEY   = 32'h0010_4011,
    parameter logic [31:0] PAGE_BASE = 32'h0000_00B0,
    parameter int          PAGES     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input lcd_mode_e         mode,
    input logic [PAGE_W-1:0] page,
    input logic [COL_W-1:0]  col
);
    logic inst_code;
    assign inst_code = (wr_data >= DATA_W'(PAGE_BASE)) &&
                       (wr_data <= DATA_W'(PAGE_BASE + PAGES - 1));

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode == MODE_OFF && page == '0 && col == '0));

    a_r2_data_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(MODE_OFS) && wr_data == DATA_W'(DATA_KEY))
        |=> mode == MODE_DATA);

    a_r2_other_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(MODE_OFS) && wr_data != DATA_W'(DATA_KEY)
         && wr_data != DATA_W'(CMD_KEY)) |=> mode == MODE_OFF);

    a_r3_inst_page: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(INST_OFS) && inst_code)
        |=> (col == '0 && page == PAGE_W'($past(wr_data) - PAGE_BASE)));

    a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(DATA_OFS) && mode == MODE_DATA)
        |=> col == COL_W'($past(col) + 1));

    a_r7_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(DATA_OFS) && mode == MODE_OFF)
        |=> ($stable(col) && $stable(page)));
endmodule

bind lcd_page_writer lcd_page_writer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .PAGE_W(PAGE_W),
    .MODE_OFS(MODE_OFS), .INST_OFS(INST_OFS), .DATA_OFS(DATA_OFS),
    .DATA_KEY(DATA_KEY), .CMD_KEY(CMD_KEY), .PAGE_BASE(PAGE_BASE), .PAGES(PAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode_q), .page(page_q), .col(col_q)
);

// File: tb/lcd_page_writer_bench.sv
`timescale 1ns/1ps
module lcd_page_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic [6:0]  pix_x;
    logic [5:0]  pix_y;
    logic        pix_bit;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    lcd_page_writer u_lcd_page_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_x(pix_x), .pix_y(pix_y), .pix_bit(pix_bit)
    );

    // {req[61:58], addr[57:46], data[45:14], x[13:7], y[6:1], expected[0]}
    localparam int NV = 20;
    localparam logic [61:0] VEC [NV] = '{
        {4'd2, 12'h1AC, 32'h0010_0011, 7'd0,  6'd0,  1'b0}, // R2 data mode, R1 clear
        {4'd5, 12'h1C0, 32'h0000_0081, 7'd0,  6'd0,  1'b1}, // R5 page0 col0
        {4'd5, 12'h1C0, 32'h0000_0002, 7'd1,  6'd1,  1'b1}, // R5 col1
        {4'd3, 12'h1BC, 32'h0000_00B3, 7'd1,  6'd0,  1'b0}, // R3 page3
        {4'd3, 12'h1C0, 32'h0000_0040, 7'd0,  6'd30, 1'b1}, // R3 col reset to 0
        {4'd2, 12'h1AC, 32'h0010_4011, 7'd0,  6'd7,  1'b1}, // R2 cmd mode
        {4'd4, 12'h1C0, 32'h0000_00B5, 7'd0,  6'd30, 1'b1}, // R4 page5 via data
        {4'd7, 12'h1C0, 32'h0000_00B8, 7'd0,  6'd30, 1'b1}, // R7 out-of-range cmd
        {4'd2, 12'h1AC, 32'h0010_0011, 7'd0,  6'd40, 1'b0}, // R2 back to data
        {4'd4, 12'h1C0, 32'h0000_0001, 7'd0,  6'd40, 1'b1}, // R4 page5 col0
        {4'd7, 12'h1BC, 32'h0000_00AF, 7'd1,  6'd42, 1'b0}, // R7 inst 0xAF
        {4'd7, 12'h1C0, 32'h0000_0004, 7'd1,  6'd42, 1'b1}, // R7 col kept at 1
        {4'd2, 12'h1AC, 32'h1234_5678, 7'd1,  6'd42, 1'b1}, // R2 invalid key
        {4'd7, 12'h1C0, 32'h0000_00FF, 7'd2,  6'd40, 1'b0}, // R7 off-mode data
        {4'd2, 12'h1AC, 32'h0010_0011, 7'd2,  6'd43, 1'b0}, // R2 data mode
        {4'd7, 12'h1C0, 32'h0000_0008, 7'd2,  6'd43, 1'b1}, // R7 col still 2
        {4'd9, 12'h1B0, 32'h0000_00B0, 7'd3,  6'd40, 1'b0}, // R9 other offset
        {4'd9, 12'h1C0, 32'h0000_0010, 7'd3,  6'd44, 1'b1}, // R9 col still 3
        {4'd7, 12'h1BC, 32'h0000_01B0, 7'd4,  6'd45, 1'b0}, // R7 wide inst value
        {4'd8, 12'h1C0, 32'h0000_0020, 7'd4,  6'd45, 1'b1}  // R8 page5 col4 bit5
    };

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_pix(input logic [6:0] x, input logic [5:0] y,
                             input logic exp, input string tag);
        @(negedge clk);
        pix_x = x; pix_y = y;
        @(negedge clk);
        checks++;
        if (pix_bit !== exp) begin
            errors++;
            $display("FAIL %s pixel (%0d,%0d) actual %0b expected %0b",
                     tag, x, y, pix_bit, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        pix_x = '0; pix_y = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_pix(7'd5, 6'd5, 1'b0, "R1 clear after reset");
        // R1: data write in MODE_OFF straight after reset is dropped
        do_write(12'h1C0, 32'hFF);
        check_pix(7'd0, 6'd0, 1'b0, "R1 mode off after reset");

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][57:46], VEC[i][45:14]);
            check_pix(VEC[i][13:7], VEC[i][6:1], VEC[i][0],
                      $sformatf("R%0d vector %0d", VEC[i][61:58], i));
        end

        // R6: column wrap inside page 7 (mode is MODE_DATA)
        do_write(12'h1BC, 32'hB7);
        for (int c = 0; c < 127; c++) do_write(12'h1C0, 32'h00);
        do_write(12'h1C0, 32'h80);
        do_write(12'h1C0, 32'h02);
        check_pix(7'd127, 6'd63, 1'b1, "R6 last column");
        check_pix(7'd0, 6'd57, 1'b1, "R6 wrap to column 0");
        check_pix(7'd126, 6'd63, 1'b0, "R6 zero fill");

        // R1: reset clears the frame store and pointers
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check_pix(7'd0, 6'd0, 1'b0, "R1 frame cleared");
        check_pix(7'd127, 6'd63, 1'b0, "R1 frame cleared far");
        do_write(12'h1AC, 32'h0010_0011);
        do_write(12'h1C0, 32'h01);
        check_pix(7'd0, 6'd0, 1'b1, "R1 pointers at origin");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule